// File: doc/BRIEF.md
# Dual-Socket Card Power Switch Driver

This block controls the external power switch that feeds supply voltage (VCC) and programming voltage (VPP) to two card sockets. Each socket presents a 4-bit power request. The block turns these requests into switch commands in one of two output styles, picked by `par_mode`.

With `par_mode` high, the parallel style is used. Each socket gets its own low-active 3.3 V and 5 V supply enables and two high-active VPP enables. One VPP enable routes VCC to VPP; the other selects the programming voltage. The enables are registered. A move from one supply level straight to another always spends one clock with both enables off.

With `par_mode` low, the serial style is used. A slow reference clock of about 10 to 100 kHz, usually 32 kHz, is shared with the switch. The block sends both request codes as one 8-bit frame on a data line and ends each frame with a latch pulse. The parallel pins are released for other uses (`par_oe` low) and their enables are held off. A new frame goes out whenever the requests differ from the last frame sent. After reset an all-off frame is sent.

Top module: `sock_pwr_if`

## Requirements
- R1: After reset, every parallel enable is inactive, `ser_latch` is low, and the first serial frame is 8'h00.
- R2: Request bits [3:2] select VCC: 2'b01 is 3.3 V (`vcc3_n` low), 2'b10 is 5 V (`vcc5_n` low), and 2'b00 or 2'b11 is off. In parallel mode the output follows a request from the first rising clock edge after it is applied.
- R3: Request bits [1:0] select VPP: 2'b01 drives `vpp_vcc` high, 2'b10 drives `vpp_pgm` high, and 2'b00 or 2'b11 drives neither.
- R4: Per socket, `vcc3_n` and `vcc5_n` are never low together, and `vpp_vcc` and `vpp_pgm` are never high together.
- R5: A direct change between 3.3 V and 5 V, or between VPP-from-VCC and programming voltage, holds both enables of that pair inactive for exactly one clock before the new enable turns on.
- R6: With `par_mode` low, `par_oe` is low and all parallel enables go inactive one clock later. With `par_mode` high, `ser_data` and `ser_latch` are held low.
- R7: A serial frame is {req_a, req_b}, bit 7 first. Each bit changes shortly after a falling edge of `ref_clk` and is held for one full reference period.
- R8: After the last bit, `ser_latch` is high for exactly one reference period, and `ser_data` is low while it is high.
- R9: A request change made while a frame is shifting does not disturb that frame. The new value is sent in the frame that follows.
- R10: While the requests equal the last frame sent, no further frame or latch pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | 1 selects parallel outputs, 0 selects serial outputs |
| ref_clk | input | 1 | Slow reference clock for serial timing (asynchronous) |
| req_a | input | 4 | Socket A request: [3:2] VCC code, [1:0] VPP code |
| req_b | input | 4 | Socket B request: same encoding |
| vcc3_n | output | 2 | Low-active 3.3 V enable, index 0 = A, 1 = B |
| vcc5_n | output | 2 | Low-active 5 V enable per socket |
| vpp_vcc | output | 2 | High-active VPP-from-VCC enable per socket |
| vpp_pgm | output | 2 | High-active programming-voltage enable per socket |
| par_oe | output | 1 | Parallel pins in use (drive enable) |
| ser_data | output | 1 | Serial frame data |
| ser_latch | output | 1 | Serial frame latch pulse |

## Verification
The embedded assertions check four properties on every clock: the break-before-make step between supply levels, the forced-off state outside parallel mode, a low data line during the latch, and a latch that lasts longer than one clock. The bench's cycle model also checks enable exclusivity on every clock. Other behaviours need whole reference periods and can only be shown by the bench's scenarios: the frame contents and bit order as seen at the switch's sampling edge, the exact latch width, the deferral of a change made mid-frame, and the silence when nothing changes.

// File: rtl/sock_pwr_if.sv
module sock_pwr_if #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode,
  input  logic       ref_clk,
  input  logic [3:0] req_a,
  input  logic [3:0] req_b,
  output logic [1:0] vcc3_n,
  output logic [1:0] vcc5_n,
  output logic [1:0] vpp_vcc,
  output logic [1:0] vpp_pgm,
  output logic       par_oe,
  output logic       ser_data,
  output logic       ser_latch
);

  localparam int FRAME = 8;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LATCH} sst_t;

  logic [SYNC:0]  ref_sh;
  logic           fe;
  sst_t           st;
  logic           init_q, dat_q, lat_q;
  logic [FRAME-1:0] sent_q, sreg;
  logic [3:0]     cnt;
  logic [FRAME-1:0] req_cat, frame_n;

  always_ff @(posedge clk)
    if (!rst_n) ref_sh <= '0;
    else        ref_sh <= {ref_sh[SYNC-1:0], ref_clk};

  assign fe      = ref_sh[SYNC] & ~ref_sh[SYNC-1];
  assign req_cat = {req_a, req_b};
  assign frame_n = init_q ? '0 : req_cat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      init_q <= 1'b1;
      sent_q <= '0;
      sreg   <= '0;
      cnt    <= '0;
      dat_q  <= 1'b0;
      lat_q  <= 1'b0;
    end else if (fe) begin
      case (st)
        S_IDLE:
          if (init_q || req_cat != sent_q) begin
            dat_q  <= frame_n[FRAME-1];
            sreg   <= {frame_n[FRAME-2:0], 1'b0};
            sent_q <= frame_n;
            init_q <= 1'b0;
            cnt    <= 4'd1;
            st     <= S_SHIFT;
          end
        S_SHIFT:
          if (cnt == 4'(FRAME)) begin
            dat_q <= 1'b0;
            lat_q <= 1'b1;
            st    <= S_LATCH;
          end else begin
            dat_q <= sreg[FRAME-1];
            sreg  <= {sreg[FRAME-2:0], 1'b0};
            cnt   <= cnt + 4'd1;
          end
        default: begin
          lat_q <= 1'b0;
          st    <= S_IDLE;
        end
      endcase
    end
  end

  assign ser_data  = dat_q & ~par_mode;
  assign ser_latch = lat_q & ~par_mode;
  assign par_oe    = par_mode;

  for (genvar i = 0; i < 2; i++) begin : g_sock
    logic [3:0] r;
    logic [1:0] vc_q, vp_q, vc_t, vp_t;

    assign r    = (i == 0) ? req_a : req_b;
    assign vc_t = (par_mode && (r[3:2] == 2'd1 || r[3:2] == 2'd2)) ? r[3:2] : 2'd0;
    assign vp_t = (par_mode && (r[1:0] == 2'd1 || r[1:0] == 2'd2)) ? r[1:0] : 2'd0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vc_q <= 2'd0;
        vp_q <= 2'd0;
      end else begin
        vc_q <= (vc_q != 2'd0 && vc_t != 2'd0 && vc_t != vc_q) ? 2'd0 : vc_t;
        vp_q <= (vp_q != 2'd0 && vp_t != 2'd0 && vp_t != vp_q) ? 2'd0 : vp_t;
      end
    end

    assign vcc3_n[i]  = (vc_q != 2'd1);
    assign vcc5_n[i]  = (vc_q != 2'd2);
    assign vpp_vcc[i] = (vp_q == 2'd1);
    assign vpp_pgm[i] = (vp_q == 2'd2);

    AST_BBM_3TO5: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc3_n[i] |=> vcc5_n[i]); // R5
    AST_BBM_5TO3: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc5_n[i] |=> vcc3_n[i]); // R5
    AST_BBM_VPP: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_vcc[i] |=> !vpp_pgm[i]); // R5
    AST_BBM_PGM: assert property (@(posedge clk) disable iff (!rst_n)
      vpp_pgm[i] |=> !vpp_vcc[i]); // R5
    AST_SER_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !par_mode |=> (vcc3_n[i] && vcc5_n[i] && !vpp_vcc[i] && !vpp_pgm[i])); // R6
  end

  AST_LATCH_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ser_latch |-> !ser_data); // R8
  AST_LATCH_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_latch) && !par_mode) |=> (ser_latch || par_mode)); // R8

endmodule

// File: tb/sock_pwr_if_bench.sv
module sock_pwr_if_bench;
  localparam int CLK_P  = 10;
  localparam int REF_HC = 20;

  logic clk = 1'b0, rst_n = 1'b0, par_mode = 1'b0, ref_clk = 1'b0;
  logic [3:0] req_a = '0, req_b = '0;
  logic [1:0] vcc3_n, vcc5_n, vpp_vcc, vpp_pgm;
  logic par_oe, ser_data, ser_latch;

  int vectors = 0, fails = 0, cyc = 0;
  int mvc [2];
  int mvp [2];
  logic [7:0] bits = '0;
  logic [7:0] frames [$];
  int lat_lens [$];
  int lat_run = 0;
  bit par_sweep = 0;

  sock_pwr_if u_sock_pwr_if (.*);

  always #(CLK_P/2) clk = ~clk;
  initial begin
    #3;
    forever #(CLK_P*REF_HC) ref_clk = ~ref_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int tgt(input logic pm, input logic [1:0] f);
    return (pm && (f == 2'd1 || f == 2'd2)) ? int'(f) : 0;
  endfunction

  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      logic [3:0] r;
      int tc, tp;
      r  = (s == 0) ? req_a : req_b;
      tc = tgt(par_mode, r[3:2]);
      tp = tgt(par_mode, r[1:0]);
      if (!rst_n) begin
        mvc[s] <= 0;
        mvp[s] <= 0;
      end else begin
        mvc[s] <= (mvc[s] != 0 && tc != 0 && tc != mvc[s]) ? 0 : tc;
        mvp[s] <= (mvp[s] != 0 && tp != 0 && tp != mvp[s]) ? 0 : tp;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int s = 0; s < 2; s++) begin
        chk(vcc3_n[s] == (mvc[s] != 1) && vcc5_n[s] == (mvc[s] != 2), "R2 R5 vcc",
            {vcc3_n[s], vcc5_n[s]}, {mvc[s] != 1, mvc[s] != 2});
        chk(vpp_vcc[s] == (mvp[s] == 1) && vpp_pgm[s] == (mvp[s] == 2), "R3 R5 vpp",
            {vpp_vcc[s], vpp_pgm[s]}, {mvp[s] == 1, mvp[s] == 2});
        chk(vcc3_n[s] | vcc5_n[s], "R4 vcc exclusive", {vcc3_n[s], vcc5_n[s]}, 1);
        chk(!(vpp_vcc[s] & vpp_pgm[s]), "R4 vpp exclusive", {vpp_vcc[s], vpp_pgm[s]}, 0);
      end
      chk(par_oe == par_mode, "R6 par_oe", par_oe, par_mode);
      if (par_mode) chk(!ser_data && !ser_latch, "R6 serial quiet", {ser_data, ser_latch}, 0);
    end
    if (ser_latch) lat_run++;
    else if (lat_run != 0) begin
      lat_lens.push_back(lat_run);
      lat_run = 0;
    end
  end

  always @(posedge ref_clk) begin
    if (ser_latch) frames.push_back(bits);
    else bits <= {bits[6:0], ser_data};
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wait_frame(output logic [7:0] f, output int len);
    int t = 0;
    while (frames.size() == 0 && t < 40*REF_HC) begin
      @(negedge clk);
      t++;
    end
    repeat (2*REF_HC + 4) @(negedge clk);
    if (frames.size() == 0) begin
      f = 8'hxx;
      len = -1;
    end else begin
      f = frames.pop_front();
      len = (lat_lens.size() != 0) ? lat_lens.pop_front() : -1;
    end
  endtask

  task automatic flush;
    repeat (50*REF_HC) @(negedge clk);
    frames.delete();
    lat_lens.delete();
  endtask

  initial begin
    logic [7:0] f;
    int len;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vcc3_n == 2'b11 && vcc5_n == 2'b11 && vpp_vcc == 0 && vpp_pgm == 0 && !ser_latch,
        "R1 reset outputs", {vcc3_n, vcc5_n, vpp_vcc, vpp_pgm}, 8'hF0);
    wait_frame(f, len);
    chk(f === 8'h00, "R1 first frame", f, 0);
    chk(len == 2*REF_HC, "R8 latch width", len, 2*REF_HC);

    par_mode = 1'b1;
    req_a = 4'b0100; req_b = 4'b1000;
    @(negedge clk);
    chk(!vcc3_n[0] && vcc5_n[0], "R2 A 3.3V", {vcc3_n[0], vcc5_n[0]}, 2'b01);
    chk(vcc3_n[1] && !vcc5_n[1], "R2 B 5V", {vcc3_n[1], vcc5_n[1]}, 2'b10);
    req_a = 4'b1000;
    @(negedge clk);
    chk(vcc3_n[0] && vcc5_n[0], "R5 gap 3.3 to 5", {vcc3_n[0], vcc5_n[0]}, 2'b11);
    @(negedge clk);
    chk(vcc3_n[0] && !vcc5_n[0], "R5 then 5V", {vcc3_n[0], vcc5_n[0]}, 2'b10);
    req_a = 4'b1101; req_b = 4'b0110;
    @(negedge clk);
    chk(vcc3_n[0] && vcc5_n[0], "R2 code 11 off", {vcc3_n[0], vcc5_n[0]}, 2'b11);
    chk(vpp_vcc[0] && !vpp_pgm[0], "R3 vpp from vcc", {vpp_vcc[0], vpp_pgm[0]}, 2'b10);
    chk(!vpp_vcc[1] && vpp_pgm[1], "R3 vpp program", {vpp_vcc[1], vpp_pgm[1]}, 2'b01);
    req_a = 4'b0010;
    @(negedge clk);
    chk(!vpp_vcc[0] && !vpp_pgm[0], "R5 vpp gap", {vpp_vcc[0], vpp_pgm[0]}, 0);
    @(negedge clk);
    chk(vpp_pgm[0], "R5 vpp then pgm", vpp_pgm[0], 1);
    req_b = 4'b0111;
    @(negedge clk);
    chk(!vpp_vcc[1] && !vpp_pgm[1], "R3 vpp code 11", {vpp_vcc[1], vpp_pgm[1]}, 0);
    for (int k = 0; k < 16; k++) begin
      req_a = 4'(k); req_b = 4'(15 - k);
      repeat (3) @(negedge clk);
    end
    repeat (30*REF_HC) @(negedge clk);
    chk(frames.size() == 0, "R6 no latch in parallel", frames.size(), 0);

    req_a = 4'b0101; req_b = 4'b0101;
    par_mode = 1'b0;
    @(negedge clk);
    chk(!par_oe, "R6 released", par_oe, 0);
    @(negedge clk);
    chk(vcc3_n == 2'b11 && vcc5_n == 2'b11 && vpp_vcc == 0 && vpp_pgm == 0,
        "R6 serial enables off", {vcc3_n, vcc5_n, vpp_vcc, vpp_pgm}, 8'hF0);
    flush();

    req_a = 4'h5; req_b = 4'hA;
    wait_frame(f, len);
    chk(f === 8'h5A, "R7 frame 5A", f, 8'h5A);
    chk(len == 2*REF_HC, "R8 latch width", len, 2*REF_HC);
    req_a = 4'hC; req_b = 4'h3;
    wait_frame(f, len);
    chk(f === 8'hC3, "R7 frame C3", f, 8'hC3);

    req_a = 4'h9; req_b = 4'h6;
    repeat (3*2*REF_HC) @(negedge clk);
    req_a = 4'h2; req_b = 4'hE;
    wait_frame(f, len);
    chk(f === 8'h96, "R9 frame in flight kept", f, 8'h96);
    wait_frame(f, len);
    chk(f === 8'h2E, "R9 change sent next", f, 8'h2E);

    frames.delete();
    repeat (15*2*REF_HC) @(negedge clk);
    chk(frames.size() == 0, "R10 no frame when unchanged", frames.size(), 0);
    chk(!ser_data, "R10 idle line low", ser_data, 0);

    summary();
  end
endmodule